// File: doc/BRIEF.md
# Direct-Mapped Read Cache Controller

This block places a read-only, direct-mapped cache between a processor load port and a slow main-memory port. Each 32-bit byte address is divided into a tag, a line index and a line offset. Every address belongs to exactly one line. A load first spends a fixed lookup time comparing the stored tag and valid bit of that line. On a hit, the addressed word is read out of the data array after a fixed data-access time.

On a miss, the controller refills the whole line from memory before it answers. It reads the line from word 0 upwards. The first word is captured a long fixed time after the refill starts, and each following word a short fixed time after the one before it. Once the last word is written, the controller sets the line's tag and valid bit. It then reads the requested word out of the data array like a hit.

The cache never holds modified data, so a line with a different tag is simply overwritten. Two 32-bit counters record completed hits and misses. The controller takes one request at a time.

Top module: `dm_read_cache`

## Requirements
- R1: After reset the following hold: req_ready is 1, resp_valid is 0, mem_rd is 0, both counters are 0, and every line is invalid. The first load to any address after a reset is therefore a miss.
- R2: The address fields are tag = addr[31:15], index = addr[14:6] and word = addr[5:2]. Bits addr[1:0] have no effect on hit or miss or on the returned word.
- R3: A hit raises resp_valid exactly LOOKUP_LAT+READ_LAT cycles (5 by default) after the clock edge that accepts the request.
- R4: On a miss, mem_rd is high for one cycle per word, 16 times in total. The first strobe is captured LOOKUP_LAT+FIRST_LAT edges after acceptance, and each later one NEXT_LAT edges after the previous one. mem_addr carries the line base plus 4×k for word k, in ascending order. resp_valid follows READ_LAT cycles after the last word, which is 100 cycles after acceptance by default.
- R5: On a hit, resp_data is the memory word at the request address with bits [1:0] cleared, taken from the filled line through the word-select bits.
- R6: On a miss, resp_data is the requested word of the freshly filled line. A later load to the same line hits.
- R7: A miss on a valid line that holds another tag replaces that line's tag and data with no write to memory. A following load with the old tag misses again.
- R8: req_ready is low from the accepting edge until the edge that raises resp_valid. A request offered while req_ready is low is ignored. resp_valid is a one-cycle pulse, and req_ready is high in that cycle.
- R9: hit_count or miss_count goes up by exactly one at the edge that raises resp_valid, according to the outcome. At every other edge neither counter changes.
- R10: mem_rd is never high during a hit, while idle, or in a response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request offered |
| req_addr | input | 32 | Load byte address |
| req_ready | output | 1 | Controller idle, request taken at this edge if offered |
| resp_valid | output | 1 | One-cycle pulse: resp_data holds the loaded word |
| resp_data | output | 32 | Loaded word |
| mem_rd | output | 1 | Refill word capture strobe |
| mem_addr | output | 32 | Byte address of the refill word being read |
| mem_rdata | input | 32 | Memory word for mem_addr, valid whenever mem_rd is high |
| hit_count | output | 32 | Completed hits |
| miss_count | output | 32 | Completed misses |

## Verification
The bench keeps every latency and the 64-byte line at their defaults, but builds the cache with 16 lines. Index bits are then addr[9:6] and the tag is addr[31:10], so the bench can fill every line, revisit each one as a hit, and create conflicting tags cheaply. The full 100-cycle refill timing is checked on every miss. An all-ones address exercises the widest tag and the top index, and a second reset shows that filled lines are forgotten.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_FILL,
      ST_READ
   } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
   parameter int LINES = 512,
   parameter int IDX_W = 9,
   parameter int TAG_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx,
   input  logic [TAG_W-1:0] tag,
   input  logic             install,
   output logic             hit
);
   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];

   if (2**IDX_W != LINES) begin : g_bad_idx
      $error("tag store: LINES must equal 2**IDX_W");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else if (install) begin
         valid_q[idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (install) begin
         tag_q[idx] <= tag;
      end
   end

   assign hit = valid_q[idx] && (tag_q[idx] == tag);
endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
   parameter int LINES  = 512,
   parameter int IDX_W  = 9,
   parameter int WORDS  = 16,
   parameter int WSEL_W = 4,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic [IDX_W-1:0]  idx,
   input  logic              wr_en,
   input  logic [WSEL_W-1:0] wr_word,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [WSEL_W-1:0] rd_word,
   output logic [WORD_W-1:0] rd_data
);
   localparam int LINE_W = WORDS * WORD_W;

   logic [LINE_W-1:0] line_q [LINES];

   if (2**WSEL_W != WORDS) begin : g_bad_words
      $error("line store: WORDS must equal 2**WSEL_W");
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         line_q[idx][int'(wr_word)*WORD_W +: WORD_W] <= wr_data;
      end
   end

   assign rd_data = line_q[idx][int'(rd_word)*WORD_W +: WORD_W];
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
   import dmc_pkg::*;
#(
   parameter int LOOKUP_LAT = 2,
   parameter int READ_LAT   = 3,
   parameter int FIRST_LAT  = 50,
   parameter int NEXT_LAT   = 3,
   parameter int WORDS      = 16,
   parameter int WSEL_W     = 4,
   parameter int CNT_W      = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              hit,
   output logic              req_ready,
   output logic              accept,
   output logic              fill_take,
   output logic [WSEL_W-1:0] fill_word,
   output logic              install,
   output logic              resp_fire,
   output logic              resp_miss
);
   dmc_state_e        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [WSEL_W-1:0] word_q;
   logic              miss_q;
   logic              last_word;

   assign req_ready = (state_q == ST_IDLE);
   assign accept    = req_ready && req_valid;
   assign fill_take = (state_q == ST_FILL) && (cnt_q == '0);
   assign fill_word = word_q;
   assign last_word = (word_q == WSEL_W'(WORDS - 1));
   assign install   = fill_take && last_word;
   assign resp_fire = (state_q == ST_READ) && (cnt_q == '0);
   assign resp_miss = miss_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         word_q  <= '0;
         miss_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  state_q <= ST_LOOKUP;
                  cnt_q   <= CNT_W'(LOOKUP_LAT - 1);
               end
            end
            ST_LOOKUP: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (hit) begin
                  state_q <= ST_READ;
                  cnt_q   <= CNT_W'(READ_LAT - 1);
                  miss_q  <= 1'b0;
               end else begin
                  state_q <= ST_FILL;
                  cnt_q   <= CNT_W'(FIRST_LAT - 1);
                  word_q  <= '0;
                  miss_q  <= 1'b1;
               end
            end
            ST_FILL: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (last_word) begin
                  state_q <= ST_READ;
                  cnt_q   <= CNT_W'(READ_LAT - 1);
               end else begin
                  word_q <= word_q + 1'b1;
                  cnt_q  <= CNT_W'(NEXT_LAT - 1);
               end
            end
            ST_READ: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else begin
                  state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dm_read_cache.sv
module dm_read_cache #(
   parameter int ADDR_W     = 32,
   parameter int WORD_W     = 32,
   parameter int LINES      = 512,
   parameter int LINE_BYTES = 64,
   parameter int LOOKUP_LAT = 2,
   parameter int READ_LAT   = 3,
   parameter int FIRST_LAT  = 50,
   parameter int NEXT_LAT   = 3,
   parameter int COUNT_W    = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [ADDR_W-1:0]  req_addr,
   output logic               req_ready,
   output logic               resp_valid,
   output logic [WORD_W-1:0]  resp_data,
   output logic               mem_rd,
   output logic [ADDR_W-1:0]  mem_addr,
   input  logic [WORD_W-1:0]  mem_rdata,
   output logic [COUNT_W-1:0] hit_count,
   output logic [COUNT_W-1:0] miss_count
);
   localparam int OFF_W   = $clog2(LINE_BYTES);
   localparam int BYTE_W  = $clog2(WORD_W / 8);
   localparam int WSEL_W  = OFF_W - BYTE_W;
   localparam int WORDS   = 2**WSEL_W;
   localparam int IDX_W   = $clog2(LINES);
   localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
   localparam int MAX_LAT = (FIRST_LAT > LOOKUP_LAT) ?
                            ((FIRST_LAT > READ_LAT) ? FIRST_LAT : READ_LAT) :
                            ((LOOKUP_LAT > READ_LAT) ? LOOKUP_LAT : READ_LAT);
   localparam int CNT_W   = $clog2(MAX_LAT + 1);

   if (WSEL_W < 1 || TAG_W < 1 || 2**OFF_W != LINE_BYTES) begin : g_bad_geom
      $error("dm_read_cache: line must hold several words and leave a tag");
   end
   if (LOOKUP_LAT < 1 || READ_LAT < 1 || FIRST_LAT < 1 || NEXT_LAT < 1) begin : g_bad_lat
      $error("dm_read_cache: every latency must be at least one cycle");
   end

   logic [ADDR_W-1:BYTE_W] addr_q;
   logic [IDX_W-1:0]       idx;
   logic [TAG_W-1:0]       tag;
   logic [WSEL_W-1:0]      word_sel;
   logic                   accept, hit, fill_take, install, resp_fire, resp_miss;
   logic [WSEL_W-1:0]      fill_word;
   logic [WORD_W-1:0]      rd_word_data;
   logic                   unused_byte_bits;

   assign unused_byte_bits = ^req_addr[BYTE_W-1:0];

   assign idx      = addr_q[OFF_W +: IDX_W];
   assign tag      = addr_q[ADDR_W-1 -: TAG_W];
   assign word_sel = addr_q[BYTE_W +: WSEL_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (accept) begin
         addr_q <= req_addr[ADDR_W-1:BYTE_W];
      end
   end

   dmc_ctrl #(
      .LOOKUP_LAT(LOOKUP_LAT), .READ_LAT(READ_LAT), .FIRST_LAT(FIRST_LAT),
      .NEXT_LAT(NEXT_LAT), .WORDS(WORDS), .WSEL_W(WSEL_W), .CNT_W(CNT_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hit(hit),
      .req_ready(req_ready), .accept(accept), .fill_take(fill_take),
      .fill_word(fill_word), .install(install), .resp_fire(resp_fire),
      .resp_miss(resp_miss)
   );

   dmc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk(clk), .rst_n(rst_n), .idx(idx), .tag(tag), .install(install), .hit(hit)
   );

   dmc_line_store #(
      .LINES(LINES), .IDX_W(IDX_W), .WORDS(WORDS), .WSEL_W(WSEL_W), .WORD_W(WORD_W)
   ) u_lines (
      .clk(clk), .idx(idx), .wr_en(fill_take), .wr_word(fill_word),
      .wr_data(mem_rdata), .rd_word(word_sel), .rd_data(rd_word_data)
   );

   assign mem_rd   = fill_take;
   assign mem_addr = {tag, idx, fill_word, {BYTE_W{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid <= 1'b0;
         resp_data  <= '0;
         hit_count  <= '0;
         miss_count <= '0;
      end else begin
         resp_valid <= resp_fire;
         if (resp_fire) begin
            resp_data <= rd_word_data;
            if (resp_miss) miss_count <= miss_count + 1'b1;
            else           hit_count  <= hit_count + 1'b1;
         end
      end
   end
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
   parameter int HIT_LAT  = 5,
   parameter int MISS_LAT = 100,
   parameter int WORDS    = 16,
   parameter int COUNT_W  = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic               resp_valid,
   input logic               mem_rd,
   input logic [COUNT_W-1:0] hit_count,
   input logic [COUNT_W-1:0] miss_count
);
   int unsigned lat_q;
   int unsigned fills_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q   <= 0;
         fills_q <= 0;
      end else if (req_valid && req_ready) begin
         lat_q   <= 0;
         fills_q <= 0;
      end else begin
         lat_q <= lat_q + 1;
         if (mem_rd) fills_q <= fills_q + 1;
      end
   end

   // R3 and R4: response timing and refill beat count per outcome
   assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> ((lat_q == HIT_LAT && fills_q == 0) ||
                      (lat_q == MISS_LAT && fills_q == WORDS)));

   assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);

   assert_resp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> (req_ready ##1 !resp_valid));

   assert_fill_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> (!req_ready && !resp_valid));

   assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> ((hit_count + miss_count) == ($past(hit_count) + $past(miss_count) + 1'b1)));

   assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_valid |-> ($stable(hit_count) && $stable(miss_count)));
endmodule

bind dm_read_cache dmc_checker #(
   .HIT_LAT(LOOKUP_LAT + READ_LAT),
   .MISS_LAT(LOOKUP_LAT + FIRST_LAT + NEXT_LAT * (2**($clog2(LINE_BYTES) - $clog2(WORD_W / 8)) - 1) + READ_LAT),
   .WORDS(2**($clog2(LINE_BYTES) - $clog2(WORD_W / 8))),
   .COUNT_W(COUNT_W)
) u_dmc_checker (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .resp_valid(resp_valid), .mem_rd(mem_rd), .hit_count(hit_count),
   .miss_count(miss_count)
);

// File: tb/tb_dm_read_cache.sv
`timescale 1ns/1ps
module tb_dm_read_cache;
   localparam int LINES    = 16;
   localparam int LK       = 2;
   localparam int RD       = 3;
   localparam int FIRST    = 50;
   localparam int NEXT     = 3;
   localparam int WORDS    = 16;
   localparam int OFF_W    = 6;
   localparam int IDX_W    = 4;
   localparam int HIT_LAT  = LK + RD;
   localparam int MISS_LAT = LK + FIRST + NEXT * (WORDS - 1) + RD;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_ready, resp_valid, mem_rd;
   logic [31:0] resp_data, mem_addr, mem_rdata, hit_count, miss_count;

   always #2.5 clk = ~clk;

   dm_read_cache #(
      .LINES(LINES), .LINE_BYTES(64), .LOOKUP_LAT(LK), .READ_LAT(RD),
      .FIRST_LAT(FIRST), .NEXT_LAT(NEXT)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready), .resp_valid(resp_valid), .resp_data(resp_data),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .hit_count(hit_count), .miss_count(miss_count)
   );

   function automatic logic [31:0] memf(input logic [31:0] a);
      return (a ^ 32'hA5C3_0F17) * 32'h0001_0003 + 32'h0000_0007;
   endfunction

   assign mem_rdata = memf(mem_addr);

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
      end
   endtask

   // behavioural reference model
   int          cyc = 0;
   bit          m_busy = 1'b0, m_miss = 1'b0, m_evict = 1'b0, m_byteoff = 1'b0;
   int          m_acc = 0, m_resp_at = 0, m_done_at = -10;
   logic [31:0] m_addr = '0, m_data = '0;
   bit          m_valid [LINES];
   logic [31:0] m_tag [LINES];
   int unsigned m_hits = 0, m_misses = 0;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_busy = 1'b0;
         m_done_at = -10;
         m_hits = 0;
         m_misses = 0;
         for (int i = 0; i < LINES; i++) m_valid[i] = 1'b0;
      end else if (m_busy && cyc == m_resp_at) begin
         m_busy = 1'b0;
         m_done_at = cyc;
         if (m_miss) m_misses++;
         else        m_hits++;
      end else if (!m_busy && req_valid) begin
         int          idx;
         logic [31:0] tag;
         bit          hit;
         idx = int'(req_addr[OFF_W +: IDX_W]);
         tag = req_addr >> (OFF_W + IDX_W);
         hit = m_valid[idx] && (m_tag[idx] == tag);
         m_evict = !hit && m_valid[idx];
         m_valid[idx] = 1'b1;
         m_tag[idx] = tag;
         m_miss = !hit;
         m_busy = 1'b1;
         m_acc = cyc;
         m_resp_at = cyc + (hit ? HIT_LAT : MISS_LAT);
         m_addr = req_addr;
         m_byteoff = (req_addr[1:0] != 2'b00);
         m_data = memf({req_addr[31:2], 2'b00});
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit    exp_rv, exp_rd;
         int    k;
         string lbl;
         chk(req_ready === !m_busy, "R8", "req_ready", {31'd0, req_ready}, {31'd0, !m_busy});
         exp_rv = (m_done_at == cyc);
         lbl = m_miss ? (m_evict ? "R7" : "R4") : "R3";
         chk(resp_valid === exp_rv, lbl, "resp_valid", {31'd0, resp_valid}, {31'd0, exp_rv});
         if (exp_rv) begin
            lbl = m_byteoff ? "R2" : (m_miss ? "R6" : "R5");
            chk(resp_data === m_data, lbl, "resp_data", resp_data, m_data);
         end
         k = cyc - (m_acc + LK + FIRST - 1);
         exp_rd = m_busy && m_miss && k >= 0 && (k % NEXT) == 0 && (k / NEXT) < WORDS;
         chk(mem_rd === exp_rd, "R10", "mem_rd", {31'd0, mem_rd}, {31'd0, exp_rd});
         if (exp_rd) begin
            logic [31:0] ea;
            ea = {m_addr[31:OFF_W], 6'(4 * (k / NEXT))};
            chk(mem_addr === ea, "R4", "mem_addr", mem_addr, ea);
         end
         chk(hit_count === m_hits, "R9", "hit_count", hit_count, m_hits);
         chk(miss_count === m_misses, "R9", "miss_count", miss_count, m_misses);
      end
   end

   task automatic issue(input logic [31:0] a, input bit junk);
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      if (junk) begin
         req_addr = a ^ 32'h0000_2A40;
         repeat (3) @(negedge clk);
      end
      req_valid = 1'b0;
      while (!resp_valid) @(negedge clk);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R8 watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(req_ready === 1'b1, "R1", "ready in reset", {31'd0, req_ready}, 32'd1);
      chk(resp_valid === 1'b0, "R1", "resp_valid in reset", {31'd0, resp_valid}, 32'd0);
      chk(mem_rd === 1'b0, "R1", "mem_rd in reset", {31'd0, mem_rd}, 32'd0);
      chk(hit_count === 32'd0, "R1", "hit_count in reset", hit_count, 32'd0);
      chk(miss_count === 32'd0, "R1", "miss_count in reset", miss_count, 32'd0);
      rst_n = 1'b1;

      issue(32'h0000_1004, 1'b0);   // R6 cold miss
      issue(32'h0000_103C, 1'b1);   // R5 hit, R8 junk request ignored
      issue(32'h0000_1007, 1'b0);   // R2 byte bits ignored
      issue(32'h0000_1001, 1'b0);   // R2
      issue(32'h0000_1404, 1'b1);   // R7 conflict, same index
      issue(32'h0000_1004, 1'b0);   // R7 old tag misses again
      for (int i = 0; i < LINES; i++) issue(32'h0004_0000 + 32'(i * 64 + i * 4), 1'b0);
      for (int i = 0; i < LINES; i++) issue(32'h0004_0000 + 32'(i * 64 + (15 - i) * 4), 1'b0);
      issue(32'hFFFF_FFFF, 1'b0);   // R2 top index, widest tag, conflict
      issue(32'hFFFF_FFC0, 1'b0);   // R5 hit on that line, word 0

      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      issue(32'h0004_0000, 1'b0);   // R1 filled line forgotten by reset
      @(negedge clk);
      chk(miss_count === 32'd1, "R1", "miss after reset", miss_count, 32'd1);
      chk(hit_count === 32'd0, "R1", "no hit after reset", hit_count, 32'd0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule